// File: doc/BRIEF.md
# Parallel LCD Bus Controller

This block links a simple host register port to an external LCD controller or driver over an 8-bit parallel bus. A host write to the data register is split into one, two or four bus bytes, least-significant byte first. Each byte takes one programmed bus cycle, and the strobe is active for a programmable number of clocks at the start of that cycle. A host write to the read-start register runs a single-byte read. The byte is captured into a read-data register that the host can then read back.

One bus engine serves two signalling styles, chosen by a control bit. The first is the 8080 style, with separate active-low write and read strobes. The second is the 6800 style, with a read/write direction line and an enable strobe whose polarity is programmable. A transfer requested while the bus is busy waits in a single holding slot and launches as soon as the current transfer ends. A busy bit shows software when the engine is not idle.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: The register map is host_addr 0 = control, 1 = timing, 2 = read data, 3 = read start. In control, bit 0 selects the style (0 = 8080, 1 = 6800), bit 1 sets the enable polarity, and bit 2 reads back busy. In 8080 style, bus_wr_n is low only during the strobe clocks of a write byte cycle, and bus_rd_n is low only during the strobe clocks of a read cycle. The two are never low together.
- R2: In 6800 style, bus_wr_n carries the direction. It is low for every clock of a write transfer and high otherwise, including during reads and idle.
- R3: In 6800 style, bus_rd_n carries the enable. With polarity bit 0 the enable is high during strobe clocks and low otherwise. With polarity bit 1 it is low during strobe clocks and high otherwise.
- R4: A data-register write with host_size 0, 1 or 2/3 sends 1, 2 or 4 bytes, taking bits 7:0 first. bus_d_out holds the current byte and bus_d_oe is high for every clock of a write byte cycle. Both are 0 otherwise.
- R5: Timing bits 4:0 give W and bits 10:5 give C. Each byte cycle lasts L = max(C, W+2) clocks, and the strobe is active in its first W+1 clocks. The first byte cycle begins in the clock after the edge that accepts an idle-time write.
- R6: A transfer request arriving while a transfer runs is held in one slot and starts right after the running transfer's last clock. A request arriving while the slot is full is dropped.
- R7: A request that arrives in the last clock of a transfer, with the slot empty, starts at the next edge with no idle clock in between.
- R8: busy is high from the edge that accepts a request until the edge that ends the last byte cycle of all held work.
- R9: A write to address 3 runs one read byte cycle with bus_d_oe low. bus_d_in is sampled at the edge that ends the last strobe clock, and the sampled byte reads back from address 2 in bits 7:0.
- R10: Writes to the control or timing register while busy is high have no effect.
- R11: After reset, both strobe outputs are high, bus_d_out and bus_d_oe are 0, busy is 0, control reads 0, W = 1 and C = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one clock per access |
| host_addr | input | 2 | Register select |
| host_size | input | 2 | Data write size: 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Readback of the addressed register |
| busy | output | 1 | Transfer running or waiting |
| bus_wr_n | output | 1 | Write strobe (8080) or direction (6800) |
| bus_rd_n | output | 1 | Read strobe (8080) or enable (6800) |
| bus_d_out | output | 8 | Bus data driven by the block |
| bus_d_oe | output | 1 | Output enable for bus_d_out |
| bus_d_in | input | 8 | Bus data from the pad |

## Verification
Two events can fall in the same clock. The first is the final clock of a transfer, in which a new host request also arrives. The second is the holding slot draining into the engine while a fresh request refills it. The bench provokes both by issuing a host write exactly in a transfer's last clock, and by queueing a request and then a further one during a multi-byte transfer. A pass means the next burst's first strobe clock follows the previous burst's last clock with no idle clock, and the request offered to a full slot never appears on the bus. Each byte cycle is compared clock by clock against a timing model over a sweep of style, polarity, W, C and size.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
   typedef enum logic [1:0] {
      LB_REG_CTRL = 2'd0,
      LB_REG_TIME = 2'd1,
      LB_REG_DATA = 2'd2,
      LB_REG_READ = 2'd3
   } lb_reg_e;
   localparam int LB_BUS_W = 8;
endpackage

// File: rtl/lcd_host_regs.sv
module lcd_host_regs
   import lcd_bus_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int WAIT_W     = 5,
   parameter int CYC_W      = 6,
   parameter int CNT_W      = 3,
   parameter bit ALLOW_6800 = 1'b1,
   parameter int RST_WAIT   = 1,
   parameter int RST_CYC    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic [1:0]           host_addr,
   input  logic [1:0]           host_size,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   input  logic                 busy,
   input  logic                 cap_en,
   input  logic [LB_BUS_W-1:0]  cap_byte,
   output logic                 cfg_mode,
   output logic                 cfg_elow,
   output logic [WAIT_W-1:0]    cfg_wait,
   output logic [CYC_W-1:0]     cfg_cyc,
   output logic                 req_v,
   output logic                 req_rd,
   output logic [CNT_W-1:0]     req_n,
   output logic [DATA_W-1:0]    req_data
);
   localparam int LANES = DATA_W / LB_BUS_W;

   lb_reg_e sel;
   logic cfg_wr;
   logic elow_q;
   logic [WAIT_W-1:0] wait_q;
   logic [CYC_W-1:0] cyc_q;
   logic [LB_BUS_W-1:0] rd_byte_q;
   int unsigned want;

   assign sel    = lb_reg_e'(host_addr);
   assign cfg_wr = host_we && !busy;

   if (ALLOW_6800) begin : g_mode_reg
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             mode_q <= 1'b0;
         else if (cfg_wr && sel == LB_REG_CTRL)  mode_q <= host_wdata[0];
      end
      assign cfg_mode = mode_q;
   end else begin : g_mode_fixed
      assign cfg_mode = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elow_q    <= 1'b0;
         wait_q    <= WAIT_W'(RST_WAIT);
         cyc_q     <= CYC_W'(RST_CYC);
         rd_byte_q <= '0;
      end else begin
         if (cfg_wr && sel == LB_REG_CTRL) elow_q <= host_wdata[1];
         if (cfg_wr && sel == LB_REG_TIME) begin
            wait_q <= host_wdata[WAIT_W-1:0];
            cyc_q  <= host_wdata[WAIT_W+CYC_W-1:WAIT_W];
         end
         if (cap_en) rd_byte_q <= cap_byte;
      end
   end

   always_comb begin
      case (host_size)
         2'd0:    want = 1;
         2'd1:    want = 2;
         default: want = 4;
      endcase
      req_v    = host_we && (sel == LB_REG_DATA || sel == LB_REG_READ);
      req_rd   = (sel == LB_REG_READ);
      req_n    = req_rd ? CNT_W'(1) : CNT_W'((want > LANES) ? LANES : want);
      req_data = host_wdata;
   end

   always_comb begin
      host_rdata = '0;
      case (sel)
         LB_REG_CTRL: host_rdata[2:0] = {busy, elow_q, cfg_mode};
         LB_REG_TIME: host_rdata[WAIT_W+CYC_W-1:0] = {cyc_q, wait_q};
         LB_REG_DATA: host_rdata[LB_BUS_W-1:0] = rd_byte_q;
         default:     host_rdata = '0;
      endcase
   end

   assign cfg_elow = elow_q;
   assign cfg_wait = wait_q;
   assign cfg_cyc  = cyc_q;

   // R10: configuration frozen while the engine is occupied
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cfg_wait) && $stable(cfg_cyc) && $stable(cfg_elow) && $stable(cfg_mode)));
endmodule

// File: rtl/lcd_xfer_engine.sv
module lcd_xfer_engine
   import lcd_bus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WAIT_W = 5,
   parameter int CYC_W  = 6,
   parameter int CNT_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WAIT_W-1:0]   cfg_wait,
   input  logic [CYC_W-1:0]    cfg_cyc,
   input  logic                req_v,
   input  logic                req_rd,
   input  logic [CNT_W-1:0]    req_n,
   input  logic [DATA_W-1:0]   req_data,
   output logic                busy,
   output logic                xfer_act,
   output logic                xfer_rd,
   output logic                strobe,
   output logic [LB_BUS_W-1:0] cur_byte,
   output logic                cap_en
);
   localparam int LEN_W = ((CYC_W > WAIT_W + 1) ? CYC_W : WAIT_W + 1) + 1;

   logic [LEN_W-1:0]  floor_len, len_m1, cnt_q;
   logic              act_q, rd_q;
   logic [CNT_W-1:0]  left_q;
   logic [DATA_W-1:0] sh_q;
   logic              pend_v, pend_rd;
   logic [CNT_W-1:0]  pend_n;
   logic [DATA_W-1:0] pend_data;
   logic              cyc_end, last, free, take_pend, take_req, park;

   assign floor_len = LEN_W'(cfg_wait) + LEN_W'(2);
   assign len_m1    = ((LEN_W'(cfg_cyc) < floor_len) ? floor_len : LEN_W'(cfg_cyc)) - LEN_W'(1);
   assign cyc_end   = act_q && (cnt_q == len_m1);
   assign last      = cyc_end && (left_q == CNT_W'(1));
   assign free      = !act_q || last;
   assign take_pend = free && pend_v;
   assign take_req  = free && !pend_v && req_v;
   assign park      = req_v && !pend_v && !free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         rd_q   <= 1'b0;
         cnt_q  <= '0;
         left_q <= '0;
         sh_q   <= '0;
      end else if (take_pend || take_req) begin
         act_q  <= 1'b1;
         cnt_q  <= '0;
         rd_q   <= take_pend ? pend_rd   : req_rd;
         left_q <= take_pend ? pend_n    : req_n;
         sh_q   <= take_pend ? pend_data : req_data;
      end else if (cyc_end) begin
         cnt_q <= '0;
         if (last) begin
            act_q <= 1'b0;
         end else begin
            left_q <= left_q - CNT_W'(1);
            sh_q   <= sh_q >> LB_BUS_W;
         end
      end else if (act_q) begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_rd   <= 1'b0;
         pend_n    <= '0;
         pend_data <= '0;
      end else if (take_pend || park) begin
         pend_v    <= req_v;
         pend_rd   <= req_rd;
         pend_n    <= req_n;
         pend_data <= req_data;
      end
   end

   assign busy     = act_q || pend_v;
   assign xfer_act = act_q;
   assign xfer_rd  = rd_q;
   assign strobe   = act_q && (cnt_q <= LEN_W'(cfg_wait));
   assign cur_byte = sh_q[LB_BUS_W-1:0];
   assign cap_en   = act_q && rd_q && (cnt_q == LEN_W'(cfg_wait));

   // R6: the holding slot is only occupied behind a running transfer
   assert_pend_needs_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> !pend_v);
   // R5: the phase counter stays inside the programmed cycle
   assert_cnt_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (cnt_q <= len_m1));
   // R5: the byte count only moves at the end of a full cycle
   assert_byte_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && $past(act_q) && left_q != $past(left_q)) |-> ($past(cnt_q) == $past(len_m1)));
   // R8: an offered request always leaves the engine busy
   assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_v |=> busy);
endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
   import lcd_bus_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int WAIT_W     = 5,
   parameter int CYC_W      = 6,
   parameter bit ALLOW_6800 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [1:0]        host_size,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy,
   output logic              bus_wr_n,
   output logic              bus_rd_n,
   output logic [7:0]        bus_d_out,
   output logic              bus_d_oe,
   input  logic [7:0]        bus_d_in
);
   localparam int LANES = DATA_W / LB_BUS_W;
   localparam int CNT_W = $clog2(LANES + 1);

   if (DATA_W % LB_BUS_W != 0 || LANES < 2 || LANES > 4) begin : g_bad_width
      $error("lcd_bus_ctrl: DATA_W must be 16, 24 or 32");
   end
   if (WAIT_W + CYC_W > DATA_W || WAIT_W < 1 || CYC_W < 1) begin : g_bad_timing
      $error("lcd_bus_ctrl: timing fields do not fit the host word");
   end

   logic              cfg_mode, cfg_elow;
   logic [WAIT_W-1:0] cfg_wait;
   logic [CYC_W-1:0]  cfg_cyc;
   logic              req_v, req_rd;
   logic [CNT_W-1:0]  req_n;
   logic [DATA_W-1:0] req_data;
   logic              xfer_act, xfer_rd, strobe, cap_en;
   logic [7:0]        cur_byte;
   logic              wr_cycle;

   lcd_host_regs #(
      .DATA_W(DATA_W), .WAIT_W(WAIT_W), .CYC_W(CYC_W), .CNT_W(CNT_W), .ALLOW_6800(ALLOW_6800)
   ) u_regs (
      .clk, .rst_n, .host_we, .host_addr, .host_size, .host_wdata, .host_rdata,
      .busy, .cap_en, .cap_byte(bus_d_in),
      .cfg_mode, .cfg_elow, .cfg_wait, .cfg_cyc,
      .req_v, .req_rd, .req_n, .req_data
   );

   lcd_xfer_engine #(
      .DATA_W(DATA_W), .WAIT_W(WAIT_W), .CYC_W(CYC_W), .CNT_W(CNT_W)
   ) u_engine (
      .clk, .rst_n, .cfg_wait, .cfg_cyc,
      .req_v, .req_rd, .req_n, .req_data,
      .busy, .xfer_act, .xfer_rd, .strobe, .cur_byte, .cap_en
   );

   assign wr_cycle = xfer_act && !xfer_rd;

   always_comb begin
      if (cfg_mode) begin
         bus_wr_n = !wr_cycle;
         bus_rd_n = cfg_elow ? !strobe : strobe;
      end else begin
         bus_wr_n = !(strobe && !xfer_rd);
         bus_rd_n = !(strobe && xfer_rd);
      end
   end

   assign bus_d_oe  = wr_cycle;
   assign bus_d_out = wr_cycle ? cur_byte : 8'h00;

   // R1: in 8080 style the two strobes never overlap
   assert_no_dual_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |-> (bus_wr_n || bus_rd_n));
   // R4: the data bus is only driven while the pins signal a write
   assert_oe_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_d_oe |-> (cfg_mode ? !bus_wr_n : bus_rd_n));
endmodule

// File: tb/lcd_bus_ctrl_tb.sv
module lcd_bus_ctrl_tb;
   import lcd_bus_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        host_we;
   logic [1:0]  host_addr, host_size;
   logic [31:0] host_wdata, host_rdata;
   logic        busy, bus_wr_n, bus_rd_n, bus_d_oe;
   logic [7:0]  bus_d_out, bus_d_in;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   bit m_mode, m_elow;
   int m_w, m_c;

   lcd_bus_ctrl u_dut (
      .clk, .rst_n, .host_we, .host_addr, .host_size, .host_wdata, .host_rdata,
      .busy, .bus_wr_n, .bus_rd_n, .bus_d_out, .bus_d_oe, .bus_d_in
   );

   function automatic int cyc_len();
      return (m_c < m_w + 2) ? m_w + 2 : m_c;
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_pins(string tag, bit act, bit rd, bit str, logic [7:0] b);
      logic ew, er, eo;
      logic [7:0] ed;
      eo = act && !rd;
      ed = eo ? b : 8'h00;
      if (m_mode) begin
         ew = !(act && !rd);
         er = m_elow ? !str : str;
      end else begin
         ew = !(str && !rd);
         er = !(str && rd);
      end
      chk(tag, 32'({bus_wr_n, bus_rd_n, bus_d_oe, bus_d_out}), 32'({ew, er, eo, ed}));
   endtask

   task automatic chk_idle(string tag);
      chk_pins(tag, 1'b0, 1'b0, 1'b0, 8'h00);
      chk({tag, " busy"}, 32'(busy), 32'd0);
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
      host_addr = a;
      #1;
      v = host_rdata;
   endtask

   task automatic host_write(logic [1:0] a, logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_size = s; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic configure(bit mode, bit elow, int w, int c);
      logic [31:0] v;
      host_write(LB_REG_CTRL, 2'd0, 32'({elow, mode}));
      host_write(LB_REG_TIME, 2'd0, 32'((c << 5) | w));
      m_mode = mode; m_elow = elow; m_w = w; m_c = c;
      rd_reg(LB_REG_CTRL, v);
      chk("R1 control readback", v, 32'({1'b0, elow, mode}));
      rd_reg(LB_REG_TIME, v);
      chk("R5 timing readback", v, 32'((c << 5) | w));
   endtask

   // Checks every clock of one transfer, starting in its first clock;
   // optional host writes are injected in the clocks inj1 and inj2.
   task automatic run_xfer(string tag, bit rd, int n, logic [31:0] data,
                           int inj1, logic [1:0] a1, logic [1:0] s1, logic [31:0] d1,
                           int inj2, logic [1:0] a2, logic [1:0] s2, logic [31:0] d2);
      int len;
      len = cyc_len();
      for (int i = 0; i < n * len; i++) begin
         if (i > 0) begin
            @(negedge clk);
            host_we = 1'b0;
         end
         chk_pins(tag, 1'b1, rd, (i % len) <= m_w, 8'(data >> (8 * (i / len))));
         chk("R8 busy during transfer", 32'(busy), 32'd1);
         bus_d_in = 8'hA0 + 8'(i);
         if (i == inj1) begin
            host_we = 1'b1; host_addr = a1; host_size = s1; host_wdata = d1;
         end else if (i == inj2) begin
            host_we = 1'b1; host_addr = a2; host_size = s2; host_wdata = d2;
         end
      end
      @(negedge clk);
      host_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int ws[3];
      int cs[3];
      int seed;
      int len;
      ws = '{0, 1, 3};
      cs = '{0, 3, 6};
      seed = 0;
      rst_n = 1'b0; host_we = 1'b0; host_addr = 2'd0; host_size = 2'd0;
      host_wdata = '0; bus_d_in = 8'h00;
      m_mode = 1'b0; m_elow = 1'b0; m_w = 1; m_c = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      chk_idle("R11 reset pins");
      rd_reg(LB_REG_CTRL, v);
      chk("R11 reset control", v, 32'd0);
      rd_reg(LB_REG_TIME, v);
      chk("R11 reset timing", v, 32'h001);

      // Sweep of style, polarity, W, C and size
      for (int md = 0; md < 2; md++) begin
         for (int el = 0; el < 2; el++) begin
            for (int wi = 0; wi < 3; wi++) begin
               for (int ci = 0; ci < 3; ci++) begin
                  configure(md[0], el[0], ws[wi], cs[ci]);
                  for (int sz = 0; sz < 4; sz++) begin
                     logic [31:0] d;
                     int n;
                     d = 32'h8C4A1F36 ^ (32'(seed) * 32'h01030507);
                     seed++;
                     n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
                     host_write(LB_REG_DATA, 2'(sz), d);
                     run_xfer(md ? "R2 R3 R4 R5" : "R1 R4 R5", 1'b0, n, d,
                              -1, 2'd0, 2'd0, 32'd0, -1, 2'd0, 2'd0, 32'd0);
                     chk_idle(md ? "R2 R3 idle" : "R1 idle");
                  end
                  host_write(LB_REG_READ, 2'd0, 32'd0);
                  run_xfer(md ? "R9 R2 R3 read" : "R9 R1 read", 1'b1, 1, 32'd0,
                           -1, 2'd0, 2'd0, 32'd0, -1, 2'd0, 2'd0, 32'd0);
                  chk_idle("R9 after read");
                  rd_reg(LB_REG_DATA, v);
                  chk("R9 captured byte", v, 32'(8'hA0 + 8'(ws[wi])));
               end
            end
         end
      end

      // R6: queued request plus a dropped one while the slot is full
      configure(1'b0, 1'b0, 1, 4);
      host_write(LB_REG_DATA, 2'd1, 32'h0000_5AC3);
      run_xfer("R6 first burst", 1'b0, 2, 32'h0000_5AC3,
               1, LB_REG_DATA, 2'd0, 32'h0000_0077, 2, LB_REG_DATA, 2'd2, 32'hDEAD_BEEF);
      run_xfer("R6 queued burst", 1'b0, 1, 32'h0000_0077,
               -1, 2'd0, 2'd0, 32'd0, -1, 2'd0, 2'd0, 32'd0);
      chk_idle("R6 dropped request absent");

      // R7: request in the very last clock launches with no gap
      len = cyc_len();
      host_write(LB_REG_DATA, 2'd0, 32'h0000_0012);
      run_xfer("R7 first burst", 1'b0, 1, 32'h0000_0012,
               len - 1, LB_REG_DATA, 2'd0, 32'h0000_00E9, -1, 2'd0, 2'd0, 32'd0);
      run_xfer("R7 back-to-back burst", 1'b0, 1, 32'h0000_00E9,
               -1, 2'd0, 2'd0, 32'd0, -1, 2'd0, 2'd0, 32'd0);
      chk_idle("R7 idle");

      // R10: configuration writes while busy are ignored
      host_write(LB_REG_DATA, 2'd2, 32'h1357_9BDF);
      run_xfer("R10 timing unchanged", 1'b0, 4, 32'h1357_9BDF,
               2, LB_REG_TIME, 2'd0, 32'((9 << 5) | 5), 3, LB_REG_CTRL, 2'd0, 32'h3);
      chk_idle("R10 idle");
      rd_reg(LB_REG_TIME, v);
      chk("R10 timing kept", v, 32'((4 << 5) | 1));
      rd_reg(LB_REG_CTRL, v);
      chk("R10 control kept", v, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule